// File: doc/BRIEF.md
# Iterative AES-128 Block Decryptor

This block recovers one 128-bit plaintext block from a ciphertext block under AES-128. It does one inverse round per clock cycle. The eleven round keys come in already expanded, as one flat 1408-bit bundle. Key expansion and any framing of text into blocks happen outside the block.

A start request accepted while the unit is idle loads the ciphertext XORed with the final round key. Ten round cycles follow. Each round cycle applies, in this order:

- a right rotation of the state rows;
- the inverse byte substitution, done by sixteen lookup tables;
- the XOR with the round key;
- the inverse column mixing, built from multiply-by-9/11/13/14 logic in GF(2^8).

The column mixing is left out in the tenth round. Round keys are used from the last one down to the first.

A single-cycle completion pulse marks the cycle in which the plaintext register first holds the result. The plaintext register then keeps that value until the next accepted start.

Top module: `aes128_dec_iter`

## Requirements
- R1: After reset, `busy` and `done` are low and `plain_out` is all zeros.
- R2: A `start` sampled high while `busy` is low is accepted, and `busy` is high from the next cycle on. At acceptance the state register loads `cipher_in` XOR round key 10.
- R3: Exactly ten round cycles follow an accepted start. `done` is high for exactly one cycle, ten cycles after the accepting edge. `busy` falls in that same cycle.
- R4: In the `done` cycle, `plain_out` equals the AES-128 inverse cipher of the accepted ciphertext. For example, ciphertext 69c4e0d86a7b0430d8cdb78070b4c55a under key 000102030405060708090a0b0c0d0e0f gives 00112233445566778899aabbccddeeff.
- R5: Round key i (0 to 10) occupies `round_keys[128*i+127 : 128*i]`. Key 10 is used at load, and keys 9 down to 0 are used in round cycles one through ten. Blocks use standard byte order: byte 0 is bits 127:120, and bytes fill the state column by column.
- R6: Every round except the tenth applies the inverse column mixing after the key XOR. The tenth round, which uses key 0, does not.
- R7: A `start` sampled while `busy` is high is ignored. The running block's round count and result are unaffected.
- R8: While the unit is idle and `start` is low, `plain_out` holds its value, even when `cipher_in` and `round_keys` change.
- R9: A `start` presented in the `done` cycle is accepted, so blocks can run back to back with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to decrypt `cipher_in` |
| cipher_in | input | 128 | Ciphertext block, sampled when a start is accepted |
| round_keys | input | 1408 | Eleven expanded round keys, key i at bits 128*i+127:128*i |
| busy | output | 1 | High while rounds are in progress |
| done | output | 1 | One-cycle pulse when `plain_out` becomes valid |
| plain_out | output | 128 | Plaintext result, held until the next accepted start |

## Verification
On every cycle, the assertions check the control behaviour:

- acceptance of a start only when idle;
- a round counter that steps down by one per busy cycle, even when `start` arrives mid-run;
- a busy interval of exactly ten cycles, ending in a single `done` pulse;
- a plaintext register that does not move while the unit is idle.

Whether the data path computes the right inverse cipher is shown only by the bench's scenarios. These include the standard example vector, random keys and blocks checked against an independent forward-cipher model in the bench, all-zero and all-one corner keys, mid-run start requests, and back-to-back runs.

// File: rtl/aes_dec_pkg.sv
`timescale 1ns/1ps
package aes_dec_pkg;
  localparam int BLK_W    = 128;
  localparam int N_ROUNDS = 10;
  localparam int N_KEYS   = N_ROUNDS + 1;
  localparam int KEYS_W   = BLK_W * N_KEYS;
  localparam int N_BYTES  = BLK_W / 8;

  typedef logic [BLK_W-1:0] blk_t;

  // multiply by x in GF(2^8), reduction polynomial 0x11b
  function automatic logic [7:0] gf_x2(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_x2(sh);
    end
    return acc;
  endfunction

  // multiplicative inverse as a^254 (zero maps to zero)
  function automatic logic [7:0] gf_inverse(input logic [7:0] a);
    logic [7:0] res;
    logic [7:0] pw;
    res = 8'h01;
    pw  = a;
    for (int i = 0; i < 8; i++) begin
      if (((254 >> i) & 1) == 1) res = gf_mul(res, pw);
      pw = gf_mul(pw, pw);
    end
    return res;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] a, input int n);
    return (a << n) | (a >> (8 - n));
  endfunction

  // inverse substitution: undo the affine map, then invert in the field
  function automatic logic [7:0] inv_sub_byte(input logic [7:0] a);
    logic [7:0] t;
    t = rotl8(a, 1) ^ rotl8(a, 3) ^ rotl8(a, 6) ^ 8'h05;
    return gf_inverse(t);
  endfunction

  // one column of the inverse mixing, byte 0 in bits 31:24
  function automatic logic [31:0] inv_mix_col(input logic [31:0] c);
    logic [7:0] b0, b1, b2, b3;
    b0 = c[31:24]; b1 = c[23:16]; b2 = c[15:8]; b3 = c[7:0];
    return {gf_mul(b0,8'h0e) ^ gf_mul(b1,8'h0b) ^ gf_mul(b2,8'h0d) ^ gf_mul(b3,8'h09),
            gf_mul(b0,8'h09) ^ gf_mul(b1,8'h0e) ^ gf_mul(b2,8'h0b) ^ gf_mul(b3,8'h0d),
            gf_mul(b0,8'h0d) ^ gf_mul(b1,8'h09) ^ gf_mul(b2,8'h0e) ^ gf_mul(b3,8'h0b),
            gf_mul(b0,8'h0b) ^ gf_mul(b1,8'h0d) ^ gf_mul(b2,8'h09) ^ gf_mul(b3,8'h0e)};
  endfunction

  // source byte index for the right row rotation: row r moves r places
  function automatic int inv_shift_src(input int idx);
    int r, c;
    r = idx % 4;
    c = idx / 4;
    return r + 4 * ((c - r + 4) % 4);
  endfunction
endpackage

// File: rtl/aes_inv_sbox.sv
`timescale 1ns/1ps
module aes_inv_sbox (
  input  logic [7:0] byte_in,
  output logic [7:0] byte_out
);
  import aes_dec_pkg::*;
  always_comb byte_out = inv_sub_byte(byte_in);
endmodule

// File: rtl/aes_inv_round.sv
`timescale 1ns/1ps
module aes_inv_round
  import aes_dec_pkg::*;
#(
  parameter int W = BLK_W
) (
  input  logic [W-1:0] state_in,
  input  logic [W-1:0] rkey,
  input  logic         final_rnd,
  output logic [W-1:0] state_out
);
  localparam int NB   = W / 8;
  localparam int NCOL = NB / 4;

  logic [W-1:0] shifted;
  logic [W-1:0] subbed;
  logic [W-1:0] keyed;
  logic [W-1:0] mixed;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    localparam int SRC = inv_shift_src(i);
    assign shifted[W-1-8*i -: 8] = state_in[W-1-8*SRC -: 8];
    aes_inv_sbox sbox_i (
      .byte_in  (shifted[W-1-8*i -: 8]),
      .byte_out (subbed[W-1-8*i -: 8])
    );
  end

  assign keyed = subbed ^ rkey;

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    assign mixed[W-1-32*c -: 32] = inv_mix_col(keyed[W-1-32*c -: 32]);
  end

  assign state_out = final_rnd ? keyed : mixed;
endmodule

// File: rtl/aes_dec_seq.sv
`timescale 1ns/1ps
module aes_dec_seq #(
  parameter int NR = 10,
  localparam int CW = $clog2(NR + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] rnd_cnt,
  output logic          load_evt,
  output logic          step_evt,
  output logic          last_evt
);
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          done_q;

  assign load_evt = start & ~busy_q;
  assign step_evt = busy_q;
  assign last_evt = busy_q && (cnt_q == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_evt) begin
        cnt_q  <= CW'(NR);
        busy_q <= 1'b1;
      end else if (step_evt) begin
        cnt_q <= cnt_q - CW'(1);
        if (last_evt) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rnd_cnt = cnt_q;
endmodule

// File: rtl/aes128_dec_iter.sv
`timescale 1ns/1ps
module aes128_dec_iter
  import aes_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BLK_W-1:0]  cipher_in,
  input  logic [KEYS_W-1:0] round_keys,
  output logic              busy,
  output logic              done,
  output logic [BLK_W-1:0]  plain_out
);
  localparam int CW = $clog2(N_ROUNDS + 1);

  logic [CW-1:0]    rnd_cnt;
  logic             load_evt;
  logic             step_evt;
  logic             last_evt;
  logic [CW-1:0]    key_idx;
  logic [BLK_W-1:0] cur_key;
  logic [BLK_W-1:0] round_out;
  logic [BLK_W-1:0] state_q;
  logic [BLK_W-1:0] key_arr [N_KEYS];

  for (genvar k = 0; k < N_KEYS; k++) begin : g_key
    assign key_arr[k] = round_keys[BLK_W*k +: BLK_W];
  end

  aes_dec_seq #(.NR(N_ROUNDS)) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .rnd_cnt  (rnd_cnt),
    .load_evt (load_evt),
    .step_evt (step_evt),
    .last_evt (last_evt)
  );

  // key for the current round: counter value minus one (10 -> key 9, 1 -> key 0)
  assign key_idx = (rnd_cnt != '0) ? rnd_cnt - CW'(1) : '0;
  assign cur_key = key_arr[key_idx];

  aes_inv_round #(.W(BLK_W)) round_i (
    .state_in  (state_q),
    .rkey      (cur_key),
    .final_rnd (last_evt),
    .state_out (round_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= '0;
    end else if (load_evt) begin
      state_q <= cipher_in ^ key_arr[N_ROUNDS];
    end else if (step_evt) begin
      state_q <= round_out;
    end
  end

  assign plain_out = state_q;
endmodule

// File: rtl/aes128_dec_chk.sv
`timescale 1ns/1ps
module aes128_dec_chk #(
  parameter int NR = 10,
  parameter int CW = 4,
  parameter int W  = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [CW-1:0] rnd_cnt,
  input logic [W-1:0]  plain_out
);
  logic [CW:0] run_len;

  always_ff @(posedge clk) begin
    if (!rst_n) run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else run_len <= '0;
  end

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && rnd_cnt == CW'(NR)));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R3
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == (CW+1)'(NR)));

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && $past(busy)) |-> (rnd_cnt == $past(rnd_cnt) - CW'(1)));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(plain_out));
endmodule

bind aes128_dec_iter aes128_dec_chk #(
  .NR(aes_dec_pkg::N_ROUNDS), .CW(CW), .W(aes_dec_pkg::BLK_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .rnd_cnt   (rnd_cnt),
  .plain_out (plain_out)
);

// File: tb/aes128_dec_iter_tb_top.sv
`timescale 1ns/1ps
module aes128_dec_iter_tb_top;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [127:0]  cipher_in = '0;
  logic [1407:0] round_keys = '0;
  logic          busy;
  logic          done;
  logic [127:0]  plain_out;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  aes128_dec_iter dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cipher_in(cipher_in),
    .round_keys(round_keys), .busy(busy), .done(done), .plain_out(plain_out)
  );

  // ---------------- bench reference model (forward cipher) ----------------
  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0;
    logic [7:0] x = a;
    logic [7:0] y = b;
    while (y != 0) begin
      if (y[0]) p ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
      y = y >> 1;
    end
    return p;
  endfunction

  function automatic logic [7:0] m_inv(input logic [7:0] a);
    if (a == 0) return 8'h00;
    for (int v = 1; v < 256; v++)
      if (m_mul(a, 8'(v)) == 8'h01) return 8'(v);
    return 8'h00;
  endfunction

  function automatic logic [7:0] m_sbox(input logic [7:0] a);
    logic [7:0] b = m_inv(a);
    logic [7:0] s = 8'h63;
    for (int k = 0; k < 5; k++) s ^= (b << k) | (b >> (8 - k));
    return s;
  endfunction

  function automatic logic [31:0] m_subw(input logic [31:0] w);
    return {m_sbox(w[31:24]), m_sbox(w[23:16]), m_sbox(w[15:8]), m_sbox(w[7:0])};
  endfunction

  // R5: key i at bits 128*i+127 : 128*i
  function automatic logic [1407:0] m_expand(input logic [127:0] key);
    logic [31:0] w [44];
    logic [7:0]  rc = 8'h01;
    logic [1407:0] bundle = '0;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      logic [31:0] t = w[i-1];
      if (i % 4 == 0) begin
        t = m_subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = m_mul(rc, 8'h02);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++)
      bundle[128*r +: 128] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
    return bundle;
  endfunction

  function automatic logic [127:0] m_encrypt(input logic [127:0] pt, input logic [1407:0] ks);
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [127:0] out;
    for (int i = 0; i < 16; i++) s[i] = pt[127-8*i -: 8] ^ ks[127-8*i -: 8];
    for (int r = 1; r <= 10; r++) begin
      for (int i = 0; i < 16; i++) t[i] = m_sbox(s[(i % 4) + 4 * (((i / 4) + (i % 4)) % 4)]);
      for (int c = 0; c < 4; c++) begin
        logic [7:0] a0 = t[4*c], a1 = t[4*c+1], a2 = t[4*c+2], a3 = t[4*c+3];
        if (r != 10) begin
          t[4*c]   = m_mul(a0,2) ^ m_mul(a1,3) ^ a2 ^ a3;
          t[4*c+1] = a0 ^ m_mul(a1,2) ^ m_mul(a2,3) ^ a3;
          t[4*c+2] = a0 ^ a1 ^ m_mul(a2,2) ^ m_mul(a3,3);
          t[4*c+3] = m_mul(a0,3) ^ a1 ^ a2 ^ m_mul(a3,2);
        end
      end
      for (int i = 0; i < 16; i++) s[i] = t[i] ^ ks[128*r + 127 - 8*i -: 8];
    end
    for (int i = 0; i < 16; i++) out[127-8*i -: 8] = s[i];
    return out;
  endfunction

  // ---------------- checking ----------------
  task automatic check(input string req, input string what, input logic [127:0] act,
                       input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one block: start at a negedge, check cycle by cycle; leaves sim at the done negedge
  task automatic run_block(input logic [127:0] ct, input logic [1407:0] ks,
                           input logic [127:0] exp_pt, input bit mid_start);
    bit early = 1'b0;
    start = 1'b1; cipher_in = ct; round_keys = ks;
    @(negedge clk);
    start = 1'b0;
    check("R2", "busy after accept", 128'(busy), 128'(1));
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      if (mid_start && k == 3) begin start = 1'b1; cipher_in = ~ct; end
      if (mid_start && k == 4) begin start = 1'b0; cipher_in = ct; end
      if (done || !busy) early = 1'b1;
    end
    @(negedge clk);
    check("R3", "no early done/busy drop", 128'(early), 128'(0));
    check("R3", "done and busy at cycle 10", {126'd0, done, busy}, {126'd0, 1'b1, 1'b0});
    check(mid_start ? "R7" : "R4", "plaintext", plain_out, exp_pt);
  endtask

  task automatic idle_check(input logic [127:0] exp_pt);
    @(negedge clk);
    check("R3", "done one-cycle pulse", 128'(done), 128'(0));
    cipher_in = ~cipher_in;
    round_keys = ~round_keys;
    repeat (3) @(negedge clk);
    check("R8", "output held while idle", plain_out, exp_pt);
  endtask

  initial begin
    logic [127:0] fk, fp, fc, key, pt, ct;
    logic [1407:0] ks;
    int seed_ret;
    seed_ret = $urandom(32'd20250117);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1", "reset state", plain_out, 128'h0);
    check("R1", "reset flags", {126'd0, busy, done}, 128'h0);

    // FIPS example
    fk = 128'h000102030405060708090a0b0c0d0e0f;
    fp = 128'h00112233445566778899aabbccddeeff;
    fc = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    ks = m_expand(fk);
    check("R4", "bench model vector", m_encrypt(fp, ks), fc);
    run_block(fc, ks, fp, 1'b0);
    idle_check(fp);

    // R5 R6 corner keys
    for (int j = 0; j < 2; j++) begin
      key = j ? '1 : '0;
      pt = j ? '0 : '1;
      ks = m_expand(key);
      ct = m_encrypt(pt, ks);
      run_block(ct, ks, pt, 1'b0);
      idle_check(pt);
    end

    // R7 start while busy
    key = {$urandom, $urandom, $urandom, $urandom};
    pt  = {$urandom, $urandom, $urandom, $urandom};
    ks = m_expand(key);
    run_block(m_encrypt(pt, ks), ks, pt, 1'b1);
    idle_check(pt);

    // R9 back to back random blocks (start presented in each done cycle)
    for (int j = 0; j < 6; j++) begin
      key = {$urandom, $urandom, $urandom, $urandom};
      pt  = {$urandom, $urandom, $urandom, $urandom};
      ks = m_expand(key);
      run_block(m_encrypt(pt, ks), ks, pt, 1'b0);
    end
    idle_check(pt);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    finished = 1'b1;
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule